// File: doc/BRIEF.md
# Overcurrent Threshold Programmer and Trip Detector

This block decides, once per supply cycle, the current-limit level that a synchronous step-down stage is allowed to reach, and then watches the low-side switch drop in every switching cycle. After the supply is reported valid and the stage is enabled for the first time, a timed programming window runs. At the end of that window the block takes a digitized differential voltage code, divides it by three, clamps it into the allowed range and holds the result as the threshold. A high-supply indication overrides the programmed value with a fixed level.

Once the threshold is settled, each switching cycle is marked by a cycle-start pulse. During a cycle, a sample of the low-side drop code taken while the low-side switch is on and above the threshold counts as an event. The fault output rises only when two switching cycles in a row have each seen an event. A cycle without an event clears the run. Analog sensing, conversion and gate driving sit outside this block.

Top module: `ocp_guard`

## Requirements
- R1: After reset, `thr_code` is 0, `prog_done` is 0 and `oc_fault` is 0.
- R2: The programming window opens at the first clock edge where `supply_ok` and `enable` are both high; `prog_done` rises exactly WIN_CYCLES clock edges later (WIN_CYCLES = CLK_HZ/1e6 * WIN_US). Later changes of `enable` do not reopen the window.
- R3: At the edge that sets `prog_done`, the threshold becomes floor(`prog_code`/3) (codes are in 1 mV steps) and is held after that; later changes of `prog_code` leave `thr_code` unchanged.
- R4: A quotient from 1 to 49 gives a threshold of 50; a quotient above 500 gives 500.
- R5: A quotient of 0 (`prog_code` from 0 to 2, no programming resistor) gives the maximum threshold 500.
- R6: If `hi_supply` is high at a clock edge while `supply_ok` is high, `thr_code` reads 400 from that edge on, also during the window, until `supply_ok` falls.
- R7: An event is a clock edge with `prog_done` high, `ls_on` high and `drop_code` strictly greater than `thr_code`; equal codes and samples with `ls_on` low are not events.
- R8: A switching cycle ends at the edge where `cyc_start` is high (a hit at that same edge still belongs to the ending cycle). `oc_fault` rises at the edge that ends the second consecutive cycle with an event and stays high while each following cycle has an event.
- R9: A cycle that ends without an event clears the consecutive count; `oc_fault` falls at that edge, and a non-event cycle between two event cycles prevents a trip.
- R10: While `supply_ok` is low, threshold, window state and fault are cleared at the next edge; a new window runs on the next power-up.
- R11: No event is counted before `prog_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above its lockout level |
| enable | input | 1 | Stage enable; its first assertion opens the window |
| hi_supply | input | 1 | Supply above the switch-over level; forces the fixed threshold |
| prog_code | input | 12 | Digitized differential programming voltage, 1 mV steps |
| ls_on | input | 1 | Low-side switch is on |
| drop_code | input | 10 | Digitized low-side drop, 1 mV steps |
| cyc_start | input | 1 | One-clock pulse at each switching-cycle boundary |
| thr_code | output | 10 | Current threshold code, 1 mV steps |
| prog_done | output | 1 | Programming window has finished |
| oc_fault | output | 1 | Two or more consecutive over-threshold cycles |

## Verification
The assertions take for granted that `cyc_start` is a single-clock pulse and that `hi_supply` is only meaningful with `supply_ok` high, so that the fixed level is seen one edge after the flag. They also assume the drop and programming codes are already synchronous to `clk`. The stimulus drives every input on the falling clock edge, keeps `cyc_start` one clock wide with `ls_on` low in that clock, and only raises `hi_supply` while the supply is valid.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    localparam int unsigned OCP_THR_MIN_DEF   = 50;
    localparam int unsigned OCP_THR_MAX_DEF   = 500;
    localparam int unsigned OCP_THR_FIXED_DEF = 400;

    // Divide a programming code by three and fold it into [lo, hi];
    // a zero quotient means no programming resistor and maps to hi.
    function automatic logic [15:0] scale_third(
        input logic [15:0] code,
        input logic [15:0] lo,
        input logic [15:0] hi
    );
        logic [15:0] q;
        q = code / 16'd3;
        if (q == 16'd0)
            return hi;
        else if (q < lo)
            return lo;
        else if (q > hi)
            return hi;
        return q;
    endfunction

endpackage

// File: rtl/ocp_thr_prog.sv
module ocp_thr_prog #(
    parameter int unsigned PROG_W     = 12,
    parameter int unsigned THR_W      = 10,
    parameter int unsigned WIN_CYCLES = 300000,
    parameter int unsigned THR_MIN    = ocp_pkg::OCP_THR_MIN_DEF,
    parameter int unsigned THR_MAX    = ocp_pkg::OCP_THR_MAX_DEF,
    parameter int unsigned THR_FIXED  = ocp_pkg::OCP_THR_FIXED_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              enable,
    input  logic              hi_supply,
    input  logic [PROG_W-1:0] prog_code,
    output logic [THR_W-1:0]  thr_code,
    output logic              prog_done
);
    import ocp_pkg::*;

    localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CYCLES - 1);

    typedef struct packed {
        logic             started;
        logic             running;
        logic             done;
        logic             fixed;
        logic [CNT_W-1:0] cnt;
        logic [THR_W-1:0] held;
    } prog_st_t;

    prog_st_t st_d, st_q;
    logic [THR_W-1:0] scaled;

    always_comb begin
        scaled = THR_W'(scale_third(16'(prog_code), 16'(THR_MIN), 16'(THR_MAX)));
        st_d   = st_q;
        if (!supply_ok) begin
            st_d = '0;
        end else begin
            if (hi_supply)
                st_d.fixed = 1'b1;
            if (!st_q.started) begin
                if (enable) begin
                    st_d.started = 1'b1;
                    st_d.running = 1'b1;
                    st_d.cnt     = '0;
                end
            end else if (st_q.running) begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.running = 1'b0;
                    st_d.done    = 1'b1;
                    st_d.held    = scaled;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign thr_code  = st_q.fixed ? THR_W'(THR_FIXED) : st_q.held;
    assign prog_done = st_q.done;

    // R2: completion only follows a running window
    a_r2_done_from_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(st_q.running));

    // R3: the held code is written once per supply cycle
    a_r3_held_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && $past(st_q.done)) |-> $stable(st_q.held));

    // R4: the held code stays inside the allowed range
    a_r4_held_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.held >= THR_W'(THR_MIN) && st_q.held <= THR_W'(THR_MAX)));

endmodule

// File: rtl/ocp_trip.sv
module ocp_trip #(
    parameter int unsigned THR_W       = 10,
    parameter int unsigned TRIP_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             arm,
    input  logic             ls_on,
    input  logic [THR_W-1:0] drop_code,
    input  logic [THR_W-1:0] thr_code,
    input  logic             cyc_start,
    output logic             oc_fault
);
    localparam int unsigned ST_W = $clog2(TRIP_CYCLES + 1);
    localparam logic [ST_W-1:0] ST_TOP = ST_W'(TRIP_CYCLES);

    typedef struct packed {
        logic            ev;
        logic [ST_W-1:0] streak;
        logic            fault;
    } trip_st_t;

    trip_st_t st_d, st_q;
    logic     hit;
    logic     closed_ev;

    always_comb begin
        hit       = arm && ls_on && (drop_code > thr_code);
        closed_ev = st_q.ev || hit;
        st_d      = st_q;
        if (clear) begin
            st_d = '0;
        end else if (cyc_start) begin
            st_d.ev = 1'b0;
            if (closed_ev) begin
                if (st_q.streak != ST_TOP)
                    st_d.streak = st_q.streak + 1'b1;
            end else begin
                st_d.streak = '0;
            end
            st_d.fault = (st_d.streak == ST_TOP);
        end else if (hit) begin
            st_d.ev = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign oc_fault = st_q.fault;

    // R8: the fault only changes to high on a cycle boundary
    a_r8_rise_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fault) |-> $past(cyc_start));

    // R9: the fault only drops on a boundary or a clear
    a_r9_fall_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.fault) |-> ($past(cyc_start) || $past(clear)));

    // R11: no event is recorded while unarmed
    a_r11_no_event_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !cyc_start && !st_q.ev) |=> !st_q.ev);

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned WIN_US      = 6000,
    parameter int unsigned PROG_W      = 12,
    parameter int unsigned THR_W       = 10,
    parameter int unsigned TRIP_CYCLES = 2,
    parameter int unsigned THR_MIN     = ocp_pkg::OCP_THR_MIN_DEF,
    parameter int unsigned THR_MAX     = ocp_pkg::OCP_THR_MAX_DEF,
    parameter int unsigned THR_FIXED   = ocp_pkg::OCP_THR_FIXED_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              enable,
    input  logic              hi_supply,
    input  logic [PROG_W-1:0] prog_code,
    input  logic              ls_on,
    input  logic [THR_W-1:0]  drop_code,
    input  logic              cyc_start,
    output logic [THR_W-1:0]  thr_code,
    output logic              prog_done,
    output logic              oc_fault
);
    localparam int unsigned WIN_CYCLES = (CLK_HZ / 1_000_000) * WIN_US;

    logic [THR_W-1:0] thr_w;
    logic             done_w;

    ocp_thr_prog #(
        .PROG_W    (PROG_W),
        .THR_W     (THR_W),
        .WIN_CYCLES(WIN_CYCLES),
        .THR_MIN   (THR_MIN),
        .THR_MAX   (THR_MAX),
        .THR_FIXED (THR_FIXED)
    ) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .enable   (enable),
        .hi_supply(hi_supply),
        .prog_code(prog_code),
        .thr_code (thr_w),
        .prog_done(done_w)
    );

    ocp_trip #(
        .THR_W      (THR_W),
        .TRIP_CYCLES(TRIP_CYCLES)
    ) u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!supply_ok),
        .arm      (done_w),
        .ls_on    (ls_on),
        .drop_code(drop_code),
        .thr_code (thr_w),
        .cyc_start(cyc_start),
        .oc_fault (oc_fault)
    );

    assign thr_code  = thr_w;
    assign prog_done = done_w;

    // R6: high-supply flag yields the fixed level on the next edge
    a_r6_fixed_level: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && hi_supply) |=> (thr_code == THR_W'(THR_FIXED)));

    // R10: an invalid supply clears every output
    a_r10_supply_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!oc_fault && !prog_done && thr_code == '0));

    // R11: a fault never exists before programming finishes
    a_r11_fault_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        oc_fault |-> prog_done);

endmodule

// File: tb/test_ocp_guard.sv
`timescale 1ns/1ps
module test_ocp_guard;

    localparam int WIN = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b0;
    logic        enable = 1'b0;
    logic        hi_supply = 1'b0;
    logic [11:0] prog_code = '0;
    logic        ls_on = 1'b0;
    logic [9:0]  drop_code = '0;
    logic        cyc_start = 1'b0;
    logic [9:0]  thr_code;
    logic        prog_done;
    logic        oc_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ocp_guard #(.CLK_HZ(1_000_000), .WIN_US(WIN)) i_ocp_guard (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
        .hi_supply(hi_supply), .prog_code(prog_code), .ls_on(ls_on),
        .drop_code(drop_code), .cyc_start(cyc_start), .thr_code(thr_code),
        .prog_done(prog_done), .oc_fault(oc_fault)
    );

    // {programming code, expected threshold}
    localparam logic [21:0] VEC [10] = '{
        {12'd0,    10'd500},   // R5
        {12'd2,    10'd500},   // R5
        {12'd3,    10'd50},    // R4
        {12'd149,  10'd50},    // R4
        {12'd152,  10'd50},    // R3
        {12'd303,  10'd101},   // R3
        {12'd1200, 10'd400},   // R3
        {12'd1502, 10'd500},   // R3
        {12'd1505, 10'd500},   // R4
        {12'd4095, 10'd500}    // R4
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic power_down();
        @(negedge clk);
        supply_ok = 1'b0; enable = 1'b0; hi_supply = 1'b0;
        ls_on = 1'b0; cyc_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic power_up(input logic [11:0] code);
        @(negedge clk);
        supply_ok = 1'b1; enable = 1'b1; prog_code = code;
        repeat (WIN) @(negedge clk);
        check("R2 done not yet", int'(prog_done), 0);
        @(negedge clk);
        check("R2 done on time", int'(prog_done), 1);
    endtask

    task automatic run_cycle(input logic ls, input logic [9:0] drop);
        @(negedge clk);
        ls_on = ls; drop_code = drop; cyc_start = 1'b0;
        repeat (3) @(negedge clk);
        cyc_start = 1'b1; ls_on = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 thr", int'(thr_code), 0);
        check("R1 done", int'(prog_done), 0);
        check("R1 fault", int'(oc_fault), 0);

        foreach (VEC[i]) begin
            power_down();
            check("R10 thr cleared", int'(thr_code), 0);
            power_up(VEC[i][21:10]);
            check("R3 R4 R5 threshold", int'(thr_code), int'(VEC[i][9:0]));
        end

        // R3 held against later code changes; R2 enable toggle
        power_down();
        power_up(12'd303);
        @(negedge clk);
        prog_code = 12'd3000; enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        repeat (WIN + 3) @(negedge clk);
        check("R3 held", int'(thr_code), 101);
        check("R2 no reopen", int'(prog_done), 1);

        // R7 equal drop and ls off are not events
        run_cycle(1'b1, 10'd101);
        run_cycle(1'b1, 10'd101);
        check("R7 equal no trip", int'(oc_fault), 0);
        run_cycle(1'b0, 10'd900);
        run_cycle(1'b0, 10'd900);
        check("R7 ls off no trip", int'(oc_fault), 0);

        // R8 trip after two consecutive event cycles
        run_cycle(1'b1, 10'd102);
        check("R8 one cycle no trip", int'(oc_fault), 0);
        run_cycle(1'b1, 10'd102);
        check("R8 trip", int'(oc_fault), 1);
        run_cycle(1'b1, 10'd600);
        check("R8 stays", int'(oc_fault), 1);
        // R9 clean cycle clears
        run_cycle(1'b0, 10'd0);
        check("R9 clear", int'(oc_fault), 0);
        run_cycle(1'b1, 10'd200);
        run_cycle(1'b1, 10'd50);
        run_cycle(1'b1, 10'd200);
        check("R9 broken run", int'(oc_fault), 0);
        run_cycle(1'b1, 10'd200);
        check("R8 retrip", int'(oc_fault), 1);

        // R10 supply drop clears fault
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check("R10 fault", int'(oc_fault), 0);
        check("R10 done", int'(prog_done), 0);

        // R6 high supply after programming, sticky
        power_up(12'd303);
        @(negedge clk);
        hi_supply = 1'b1;
        @(negedge clk);
        hi_supply = 1'b0;
        check("R6 fixed", int'(thr_code), 400);
        repeat (5) @(negedge clk);
        check("R6 sticky", int'(thr_code), 400);

        // R11 no events inside window; R6 during window
        power_down();
        @(negedge clk);
        supply_ok = 1'b1; enable = 1'b1; prog_code = 12'd303; hi_supply = 1'b1;
        run_cycle(1'b1, 10'd1000);
        check("R6 fixed in window", int'(thr_code), 400);
        run_cycle(1'b1, 10'd1000);
        check("R11 no trip in window", int'(oc_fault), 0);
        check("R11 still in window", int'(prog_done), 0);

        finish_run();
    end

endmodule